// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

The controller sits between a synchronous request port and an external 512K x 16 asynchronous static RAM with separate lower and upper byte lanes. A requester presents a word address, write data, a two-bit lane mask and a read/write flag under a valid/ready handshake. The controller then runs one complete memory cycle on the active-low chip select, output enable, write enable and byte enable pins. On a read it returns the captured word with a one-cycle valid strobe.

Every phase of a memory cycle is timed by a down-counter. The counter's load value is computed at elaboration from nanosecond timing figures for a fast or a slow speed bin and from the clock period. Each phase count is the ceiling of the timing value divided by the clock period, and is never less than one cycle. The controller drives the shared data bus only while the write strobe is low. After every read it inserts a bus turnaround, so the memory's output drivers have switched off before the controller can drive again.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, and immediately after it is released, chip select, output enable, write enable and both byte enables are high, the data bus driver is off, ready is high and the response valid strobe is low.
- R2: During an accepted read, chip select and output enable are low and write enable is high for exactly N_RD = max(1, ceil(t_rc / T_clk)) consecutive cycles. t_rc is 55 ns in the fast bin and 70 ns in the slow bin.
- R3: Read data is sampled from the bus in the last output-enable-low cycle. Lane k (mask bit 0 = bits 7:0, mask bit 1 = bits 15:8) returns the bus value when its mask bit is 1 and returns zero otherwise. The response valid strobe is high for exactly one cycle, the first cycle after output enable rises.
- R4: During an accepted write, chip select and write enable are low, output enable is high, and the bus driver is on with the request's write data. This lasts exactly N_WP = max(1, ceil(max(t_wp, t_aw, t_dw) / T_clk)) cycles. The fast bin uses 40, 45 and 25 ns; the slow bin uses 50, 60 and 30 ns.
- R5: The data bus driver is on only while write enable is low. It is never on while output enable is low.
- R6: After a read, all strobes stay high for N_HZ = max(1, ceil(t_hz / T_clk)) cycles (t_hz is 20 ns fast, 25 ns slow). Ready then returns, so a read occupies the port for N_RD + N_HZ cycles. The next write's driver turns on no earlier than N_HZ + 1 cycles after output enable rises.
- R7: After write enable rises, all strobes stay high for N_REC = max(1, N_WC - N_WP) cycles, where N_WC = ceil(t_wc / T_clk) and t_wc equals t_rc. A write therefore occupies the port for N_WP + N_REC cycles.
- R8: While chip select is low, the address equals the accepted request's address and byte enable k is low exactly when mask bit k is 1.
- R9: A request is taken only when ready is high. Ready stays low from the accepting clock edge until the cycle's last phase has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request accepted at this edge |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_mask_i | input | LANES | Lane mask, bit k selects byte k |
| rsp_valid_o | output | 1 | Read data valid strobe |
| rsp_rdata_o | output | DATA_W | Read data, masked lanes zero |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_be_n_o | output | LANES | Byte enables, active low, bit 0 = lower lane |
| mem_dq_o | output | DATA_W | Data bus outgoing value |
| mem_dq_i | input | DATA_W | Data bus incoming value |
| mem_dq_oe_o | output | 1 | Data bus driver enable |

## Verification
On every cycle, the embedded properties check the following. Write enable only falls inside chip select. The bus driver never overlaps output enable. Address and byte enables hold still across a busy cycle. The write strobe lasts exactly its computed width. The response strobe is a single-cycle pulse. Ready implies idle pins. Only the bench's scenarios can show the rest, because it needs a responding memory. That covers the exact output-enable width, the busy lengths of reads and writes, the turnaround gap before a write that follows a read, and the zeroing of masked lanes. It also covers read-back after full and partial-lane writes across a sweep of addresses.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_TA   = 3'd2,
    ST_WR   = 3'd3,
    ST_REC  = 3'd4
  } asram_state_e;

  function automatic int cyc_of(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // phase lasts load_val cycles: done in its last cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i - CNT_W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [LANES-1:0]  be_n_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [DATA_W-1:0] masked;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign masked[k*8 +: 8] = be_n_i[k] ? 8'h00 : dq_i[k*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= masked;
    end
  end

  assert_rvalid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4,
  parameter int N_RD   = 6,
  parameter int N_HZ   = 2,
  parameter int N_WP   = 5,
  parameter int N_REC  = 1,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_mask_i,
  input  logic              done_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              cap_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [LANES-1:0]  mem_be_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);
  asram_state_e state_q, state_d;
  logic accept;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_ready_o && req_valid_i;
  assign cap_o       = (state_q == ST_RD) && done_i;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        state_d    = req_we_i ? ST_WR : ST_RD;
        load_o     = 1'b1;
        load_val_o = req_we_i ? CNT_W'(N_WP) : CNT_W'(N_RD);
      end
      ST_RD: if (done_i) begin
        state_d    = ST_TA;
        load_o     = 1'b1;
        load_val_o = CNT_W'(N_HZ);
      end
      ST_WR: if (done_i) begin
        state_d    = ST_REC;
        load_o     = 1'b1;
        load_val_o = CNT_W'(N_REC);
      end
      ST_TA, ST_REC: if (done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes registered from next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mem_cs_n_o  <= 1'b1;
      mem_oe_n_o  <= 1'b1;
      mem_we_n_o  <= 1'b1;
      mem_dq_oe_o <= 1'b0;
      mem_be_n_o  <= '1;
      mem_addr_o  <= '0;
      mem_dq_o    <= '0;
    end else begin
      state_q     <= state_d;
      mem_cs_n_o  <= !(state_d == ST_RD || state_d == ST_WR);
      mem_oe_n_o  <= (state_d != ST_RD);
      mem_we_n_o  <= (state_d != ST_WR);
      mem_dq_oe_o <= (state_d == ST_WR);
      if (accept) begin
        mem_addr_o <= req_addr_i;
        mem_be_n_o <= ~req_mask_i;
        mem_dq_o   <= req_wdata_i;
      end
    end
  end

  // checker: width of the write strobe
  logic [CNT_W:0] we_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          we_run_q <= '0;
    else if (mem_we_n_o)  we_run_q <= '0;
    else                  we_run_q <= we_run_q + 1'b1;
  end

  assert_we_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_run_q == (CNT_W+1)'(N_WP)));
  assert_we_inside_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> !mem_cs_n_o && mem_oe_n_o);
  assert_no_drive_on_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o && !mem_we_n_o);
  assert_addr_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !$past(req_ready_o)) |-> $stable(mem_addr_o) && $stable(mem_be_n_o));
  assert_ready_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_cs_n_o && !mem_dq_oe_o);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter bit SLOW_BIN      = 1'b0,
  localparam int LANES        = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_mask_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [LANES-1:0]  mem_be_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  localparam int T_RC  = SLOW_BIN ? 70 : 55;
  localparam int T_WP  = SLOW_BIN ? 50 : 40;
  localparam int T_AW  = SLOW_BIN ? 60 : 45;
  localparam int T_DW  = SLOW_BIN ? 30 : 25;
  localparam int T_HZ  = SLOW_BIN ? 25 : 20;
  localparam int N_RD  = cyc_of(T_RC, CLK_PERIOD_NS);
  localparam int N_HZ  = cyc_of(T_HZ, CLK_PERIOD_NS);
  localparam int N_WP  = cyc_of(max_of(T_WP, max_of(T_AW, T_DW)), CLK_PERIOD_NS);
  localparam int N_WC  = cyc_of(T_RC, CLK_PERIOD_NS);
  localparam int N_REC = (N_WC > N_WP) ? N_WC - N_WP : 1;
  localparam int N_MAX = max_of(max_of(N_RD, N_HZ), max_of(N_WP, N_REC));
  localparam int CNT_W = $clog2(N_MAX + 1);

  logic             load, done, cap;
  logic [CNT_W-1:0] load_val;

  asram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(load), .load_val_i(load_val), .done_o(done)
  );

  asram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .N_RD(N_RD), .N_HZ(N_HZ), .N_WP(N_WP), .N_REC(N_REC)
  ) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_we_i, .req_addr_i, .req_wdata_i, .req_mask_i,
    .done_i(done), .load_o(load), .load_val_o(load_val), .cap_o(cap),
    .mem_addr_o, .mem_cs_n_o, .mem_oe_n_o, .mem_we_n_o, .mem_be_n_o,
    .mem_dq_o, .mem_dq_oe_o
  );

  asram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni,
    .cap_i(cap), .be_n_i(mem_be_n_o), .dq_i(mem_dq_i),
    .rdata_o(rsp_rdata_o), .rvalid_o(rsp_valid_o)
  );
endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int TCLK = 10;
  // fast bin figures, expectations computed here
  localparam int E_RD  = (55 + TCLK - 1) / TCLK;
  localparam int E_HZ  = (20 + TCLK - 1) / TCLK;
  localparam int E_WP  = (45 + TCLK - 1) / TCLK;
  localparam int E_WC  = (55 + TCLK - 1) / TCLK;
  localparam int E_REC = (E_WC > E_WP) ? E_WC - E_WP : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rsp_valid, cs_n, oe_n, we_n, dq_oe;
  logic [DW-1:0] rsp_rdata, dq_o, dq_i;
  logic [AW-1:0] maddr;
  logic [1:0] be_n;

  int errors = 0, checks = 0;
  logic [15:0] mem_model [64];
  logic [15:0] shadow [64];
  logic [AW-1:0] cur_addr = '0;
  logic [1:0] cur_mask = '0;
  logic [15:0] cur_wdata = '0;
  bit last_rd = 1'b0, saw_read = 1'b0, dq_oe_prev = 1'b0;
  int oe_run = 0, we_run = 0, busy = 0, hz_gap = 0;

  always #5 clk = ~clk;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(TCLK), .SLOW_BIN(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_mask_i(req_mask),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(maddr), .mem_cs_n_o(cs_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .mem_be_n_o(be_n), .mem_dq_o(dq_o), .mem_dq_i(dq_i), .mem_dq_oe_o(dq_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // responder: undriven lanes carry garbage to expose missing masking
  always_comb begin
    for (int k = 0; k < 2; k++) begin
      if (!cs_n && !oe_n && we_n && !be_n[k]) dq_i[k*8 +: 8] = mem_model[maddr[5:0]][k*8 +: 8];
      else dq_i[k*8 +: 8] = 8'hA5;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && !we_n && dq_oe)
        for (int k = 0; k < 2; k++)
          if (!be_n[k]) mem_model[maddr[5:0]][k*8 +: 8] <= dq_o[k*8 +: 8];
      // R2 output-enable width and strobe levels
      if (!oe_n) begin
        oe_run++;
        chk(!cs_n && we_n, "R2 read strobes", {29'd0, cs_n, oe_n, we_n}, 32'h1);
      end else if (oe_run > 0) begin
        chk(oe_run == E_RD, "R2 oe width", oe_run, E_RD);
        oe_run = 0;
      end
      // R4 write pulse width and data
      if (!we_n) begin
        we_run++;
        chk(!cs_n && oe_n && dq_oe && dq_o == cur_wdata, "R4 write pins", dq_o, cur_wdata);
      end else if (we_run > 0) begin
        chk(we_run == E_WP, "R4 we width", we_run, E_WP);
        we_run = 0;
      end
      // R5 bus only driven during write strobe
      if (dq_oe && (!oe_n || we_n)) chk(1'b0, "R5 contention", {31'd0, oe_n}, 32'h1);
      // R8 address and lanes held
      if (!cs_n) chk(maddr == cur_addr && be_n == ~cur_mask, "R8 addr/be", {11'd0, be_n, maddr},
                     {11'd0, ~cur_mask, cur_addr});
      // R3 strobe only after OE is off
      if (rsp_valid) chk(oe_n, "R3 valid after oe", {31'd0, oe_n}, 32'h1);
      // R6 turnaround before a write that follows a read
      if (dq_oe && !dq_oe_prev && saw_read) begin
        chk(hz_gap >= E_HZ + 1, "R6 turnaround", hz_gap, E_HZ + 1);
        saw_read = 1'b0;
      end
      if (!oe_n) begin hz_gap = 0; saw_read = 1'b1; end
      else hz_gap++;
      dq_oe_prev = dq_oe;
      // R9/R6/R7 busy length
      if (!req_ready) busy++;
      else if (busy > 0) begin
        if (last_rd) chk(busy == E_RD + E_HZ, "R6 read busy", busy, E_RD + E_HZ);
        else chk(busy == E_WP + E_REC, "R7 write busy", busy, E_WP + E_REC);
        busy = 0;
      end
    end
  end

  task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] exp;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
    cur_addr = a; cur_mask = m; cur_wdata = d; last_rd = !we;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 ready drops", {31'd0, req_ready}, 32'h0);
    if (we) begin
      for (int k = 0; k < 2; k++) if (m[k]) shadow[a[5:0]][k*8 +: 8] = d[k*8 +: 8];
    end else begin
      exp = {m[1] ? shadow[a[5:0]][15:8] : 8'h00, m[0] ? shadow[a[5:0]][7:0] : 8'h00};
      while (!rsp_valid) @(negedge clk);
      chk(rsp_rdata == exp, "R3 read data", rsp_rdata, exp);
      @(negedge clk);
      chk(!rsp_valid, "R3 single pulse", {31'd0, rsp_valid}, 32'h0);
    end
    while (!req_ready) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] addr_of(input int i);
    return AW'(i & 63) | (AW'((i * 5) & 13'h1FFF) << 6);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && oe_n && we_n && be_n == 2'b11 && !dq_oe && req_ready && !rsp_valid,
        "R1 in reset", {26'd0, cs_n, oe_n, we_n, be_n, dq_oe}, 32'h3E);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && oe_n && we_n && !dq_oe && req_ready && !rsp_valid,
        "R1 after reset", {27'd0, cs_n, oe_n, we_n, dq_oe, req_ready}, 32'h1D);
    for (int i = 0; i < 64; i++) do_op(1'b1, addr_of(i), 16'(i * 16'h0101) ^ 16'h3C5A, 2'b11);
    for (int i = 0; i < 64; i++) do_op(1'b0, addr_of(i), 16'h0, 2'(i));
    for (int i = 0; i < 64; i++) begin
      do_op(1'b1, addr_of(i), ~(16'(i) * 16'h1357), 2'((i % 3) + 1));
      do_op(1'b0, addr_of(i), 16'h0, 2'b11);
    end
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule